// File: doc/BRIEF.md
# Hysteresis Buffer Urgency Flag Generator

This block raises one urgency bit on a DMA master port when any of its buffers nears a dangerous fill level. The interconnect can then serve the outstanding requests of this master ahead of others. The block watches several read pipelines, where the risk is that the buffer runs dry. It also watches one outbound writeback pipeline, where the risk is that the buffer fills up. Fill levels arrive as plain counts, and each pipeline has its own pair of programmable thresholds, one low and one high.

Each pipeline keeps a 1-bit local flag that has three regions: set, clear and hold. This gives a hysteresis band, so the flag does not toggle while the level moves between the two thresholds. A global 2-bit mode selects between dynamic operation and off. When the mode is off, every flag is forced low and all history is discarded. The local flags are OR-reduced into the registered port bit. That bit follows no bus transaction and may change at any cycle.

Top module: `urg_flag_gen`

## Requirements
- R1: After reset every local flag and the urgency output read 0.
- R2: When the mode input is any value other than 2 (values 0, 1 and 3), every local flag and the urgency output are 0 one cycle later, whatever the levels and thresholds.
- R3: Writeback lane (the last local flag bit, index NUM_RD), in mode 2: when the level is strictly greater than its high threshold, the flag is 1 one cycle later.
- R4: Writeback lane, in mode 2: when the level is strictly less than its low threshold and not above the high threshold, the flag is 0 one cycle later. When the level lies between the thresholds, the flag keeps its value.
- R5: Read lane i (local flag bit i, level slice [i*LVL_W +: LVL_W]), in mode 2: the flag becomes 1 when the level is strictly below the low threshold. It becomes 0 when the level is strictly above the high threshold and not below the low one. Otherwise it holds.
- R6: A level exactly equal to a threshold counts as inside the band. It neither sets nor clears a flag.
- R7: The urgency output is the OR of all local flags. Both the output and the flags are registered and reflect the inputs sampled at the previous clock edge.
- R8: If the thresholds cross so that the set and clear conditions hold at once, set wins.
- R9: When the mode returns to 2 after any other value, every flag starts from 0. A level inside the band then leaves the flag at 0.
- R10: Each lane uses only its own level and threshold pair. Other lanes do not change its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Global mode, 2 = dynamic, others = off |
| rd_level_i | input | NUM_RD*LVL_W | Fill level of each read buffer, lane i in slice i |
| rd_thr_hi_i | input | NUM_RD*LVL_W | High threshold of each read lane |
| rd_thr_lo_i | input | NUM_RD*LVL_W | Low threshold of each read lane |
| wb_level_i | input | LVL_W | Fill level of the writeback buffer |
| wb_thr_hi_i | input | LVL_W | Writeback high threshold |
| wb_thr_lo_i | input | LVL_W | Writeback low threshold |
| lane_flag_o | output | NUM_RD+1 | Local flags, read lanes low, writeback lane in the top bit |
| urgent_o | output | 1 | Combined urgency bit for the master port |

## Verification
A flag with the wrong state shows up in the band cycles. There, a correct design holds its previous value, so a stuck or lost history bit appears on lane_flag_o the first cycle the level sits between the thresholds after a crossing. A swapped polarity or an off-by-one compare changes the flag one cycle after the level reaches a threshold value. A stale OR register or leftover history from a disabled period shows on urgent_o in the cycle after the mode or a level changes. The sweeps pass ramps up and down through every threshold pair, so each such error surfaces within a few cycles.

// File: rtl/urg_pkg.sv
package urg_pkg;

  typedef enum logic [1:0] {
    URG_OFF  = 2'd0,
    URG_RSV1 = 2'd1,
    URG_DYN  = 2'd2,
    URG_RSV3 = 2'd3
  } urg_mode_e;

  // Next state of a hysteresis flag: set has priority over clear.
  function automatic logic hyst_next(input logic cur,
                                     input logic set_hit,
                                     input logic clr_hit);
    if (set_hit)      return 1'b1;
    else if (clr_hit) return 1'b0;
    else              return cur;
  endfunction

endpackage

// File: rtl/urg_lane.sv
module urg_lane #(
  parameter int LVL_W = 6,
  parameter bit IS_WB = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] thr_hi,
  input  logic [LVL_W-1:0] thr_lo,
  output logic             flag_o,
  output logic             flag_next_o
);
  import urg_pkg::*;

  logic above_hi, below_lo;
  logic set_hit, clr_hit;
  logic flag_q, flag_d;

  assign above_hi = level > thr_hi;
  assign below_lo = level < thr_lo;

  generate
    if (IS_WB) begin : g_drain
      assign set_hit = above_hi;
      assign clr_hit = below_lo;
    end else begin : g_fill
      assign set_hit = below_lo;
      assign clr_hit = above_hi;
    end
  endgenerate

  assign flag_d = en ? hyst_next(flag_q, set_hit, clr_hit) : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o      = flag_q;
  assign flag_next_o = flag_d;

  // R3 / R5 / R8: a set condition raises the flag next cycle
  p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && set_hit) |=> flag_q);
  // R4 / R5: a clear condition without a set lowers it
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && clr_hit && !set_hit) |=> !flag_q);
  // R6: inside the band the flag keeps its value
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !set_hit && !clr_hit) |=> (flag_q == $past(flag_q)));
  // R2 / R9: disabled lane is cleared
  p_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !flag_q);

endmodule

// File: rtl/urg_merge.sv
module urg_merge #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] flag_next,
  output logic         urgent_o
);
  logic urgent_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) urgent_q <= 1'b0;
    else        urgent_q <= |flag_next;
  end

  assign urgent_o = urgent_q;
endmodule

// File: rtl/urg_flag_gen.sv
module urg_flag_gen #(
  parameter int NUM_RD = 3,
  parameter int LVL_W  = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              mode_i,
  input  logic [NUM_RD*LVL_W-1:0] rd_level_i,
  input  logic [NUM_RD*LVL_W-1:0] rd_thr_hi_i,
  input  logic [NUM_RD*LVL_W-1:0] rd_thr_lo_i,
  input  logic [LVL_W-1:0]        wb_level_i,
  input  logic [LVL_W-1:0]        wb_thr_hi_i,
  input  logic [LVL_W-1:0]        wb_thr_lo_i,
  output logic [NUM_RD:0]         lane_flag_o,
  output logic                    urgent_o
);
  import urg_pkg::*;

  localparam int NUM_LANES = NUM_RD + 1;

  logic                 dyn_en;
  logic [NUM_LANES-1:0] lane_next;

  assign dyn_en = (urg_mode_e'(mode_i) == URG_DYN);

  genvar gi;
  generate
    for (gi = 0; gi < NUM_RD; gi++) begin : g_rd
      urg_lane #(.LVL_W(LVL_W), .IS_WB(1'b0)) u_lane (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (dyn_en),
        .level       (rd_level_i [gi*LVL_W +: LVL_W]),
        .thr_hi      (rd_thr_hi_i[gi*LVL_W +: LVL_W]),
        .thr_lo      (rd_thr_lo_i[gi*LVL_W +: LVL_W]),
        .flag_o      (lane_flag_o[gi]),
        .flag_next_o (lane_next[gi])
      );
    end
  endgenerate

  urg_lane #(.LVL_W(LVL_W), .IS_WB(1'b1)) u_wb (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (dyn_en),
    .level       (wb_level_i),
    .thr_hi      (wb_thr_hi_i),
    .thr_lo      (wb_thr_lo_i),
    .flag_o      (lane_flag_o[NUM_RD]),
    .flag_next_o (lane_next[NUM_RD])
  );

  urg_merge #(.N(NUM_LANES)) u_merge (
    .clk       (clk),
    .rst_n     (rst_n),
    .flag_next (lane_next),
    .urgent_o  (urgent_o)
  );

  // R7: the port bit matches the OR of the lane registers
  p_or_r7: assert property (@(posedge clk) disable iff (!rst_n)
    urgent_o == (|lane_flag_o));
  // R2: any non-dynamic mode drops the port bit next cycle
  p_mode_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != 2'd2) |=> !urgent_o);

endmodule

// File: tb/urg_flag_gen_tb.sv
module urg_flag_gen_tb;
  localparam int NR = 2;
  localparam int W  = 3;
  localparam int NL = NR + 1;
  localparam int MAXV = (1 << W);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [1:0]      mode;
  logic [NR*W-1:0] rd_lvl, rd_hi, rd_lo;
  logic [W-1:0]    wb_lvl, wb_hi, wb_lo;
  logic [NR:0]     flags;
  logic            urgent;

  int n_chk = 0;
  int n_bad = 0;
  logic model [NL];

  always #2 clk = ~clk;

  urg_flag_gen #(.NUM_RD(NR), .LVL_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode),
    .rd_level_i(rd_lvl), .rd_thr_hi_i(rd_hi), .rd_thr_lo_i(rd_lo),
    .wb_level_i(wb_lvl), .wb_thr_hi_i(wb_hi), .wb_thr_lo_i(wb_lo),
    .lane_flag_o(flags), .urgent_o(urgent)
  );

  function automatic int lvl_of(int i);
    return (i == NR) ? int'(wb_lvl) : int'(rd_lvl[i*W +: W]);
  endfunction
  function automatic int hi_of(int i);
    return (i == NR) ? int'(wb_hi) : int'(rd_hi[i*W +: W]);
  endfunction
  function automatic int lo_of(int i);
    return (i == NR) ? int'(wb_lo) : int'(rd_lo[i*W +: W]);
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: update the model from the inputs seen at the edge, then compare
  task automatic step();
    string tags [NL];
    logic any;
    @(posedge clk);
    for (int i = 0; i < NL; i++) begin
      int v, h, l;
      bit danger, safe;
      v = lvl_of(i); h = hi_of(i); l = lo_of(i);
      if (i == NR) begin danger = (v - h) > 0; safe = (l - v) > 0; end
      else         begin danger = (l - v) > 0; safe = (v - h) > 0; end
      if (mode != 2'd2) begin model[i] = 1'b0; tags[i] = "R2"; end
      else begin
        if (danger && safe) tags[i] = "R8";
        else if (v == h || v == l) tags[i] = "R6";
        else if (i == NR) tags[i] = danger ? "R3" : "R4";
        else tags[i] = "R5";
        if (danger) model[i] = 1'b1;
        else if (safe) model[i] = 1'b0;
      end
    end
    #1;
    any = 1'b0;
    for (int i = 0; i < NL; i++) begin
      chk(tags[i], flags[i], model[i]);
      any = any | model[i];
    end
    chk("R7", urgent, any);
  endtask

  initial begin : watchdog
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    mode = 2'd0; rd_lvl = '0; rd_hi = '0; rd_lo = '0;
    wb_lvl = '0; wb_hi = '0; wb_lo = '0;
    for (int i = 0; i < NL; i++) model[i] = 1'b0;
    #9;
    // R1: reset state
    chk("R1", urgent, 1'b0);
    for (int i = 0; i < NL; i++) chk("R1", flags[i], 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: off modes force zero even with every lane in danger
    for (int m = 0; m < 4; m++) begin
      if (m == 2) continue;
      mode = 2'(m);
      rd_lvl = '0; rd_lo = {NR{3'd5}}; rd_hi = {NR{3'd6}};
      wb_lvl = 3'd7; wb_hi = 3'd2; wb_lo = 3'd1;
      step(); step();
    end

    // exhaustive threshold sweep, ramps up then down; lanes get different pairs (R10)
    mode = 2'd2;
    for (int h = 0; h < MAXV; h++) begin
      for (int l = 0; l < MAXV; l++) begin
        for (int k = 0; k < 2 * MAXV; k++) begin
          int r;
          r = (k < MAXV) ? k : (2 * MAXV - 1 - k);
          for (int i = 0; i < NL; i++) begin
            logic [W-1:0] lv, hv, lov;
            lv  = W'((r + 3 * i) % MAXV);
            hv  = W'((h + i) % MAXV);
            lov = W'((l + 2 * i) % MAXV);
            if (i == NR) begin wb_lvl = lv; wb_hi = hv; wb_lo = lov; end
            else begin
              rd_lvl[i*W +: W] = lv; rd_hi[i*W +: W] = hv; rd_lo[i*W +: W] = lov;
            end
          end
          step();
        end
      end
    end

    // R9: set every flag, leave mode 2, return with levels inside the band
    rd_lo = {NR{3'd3}}; rd_hi = {NR{3'd5}}; rd_lvl = {NR{3'd1}};
    wb_lo = 3'd3; wb_hi = 3'd5; wb_lvl = 3'd7;
    mode = 2'd2; step();
    for (int i = 0; i < NL; i++) chk("R9", flags[i], 1'b1);
    mode = 2'd1; step();
    rd_lvl = {NR{3'd4}}; wb_lvl = 3'd4;
    mode = 2'd2; step(); step();
    for (int i = 0; i < NL; i++) chk("R9", flags[i], 1'b0);
    chk("R9", urgent, 1'b0);

    // R10: only lane 0 in danger, others in band
    rd_lvl = {3'd4, 3'd0}; wb_lvl = 3'd4; step();
    chk("R10", flags[0], 1'b1);
    chk("R10", flags[1], 1'b0);
    chk("R10", flags[NR], 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule